// File: doc/BRIEF.md
# Single-Wire Serial Bus Master

This block is a register-mapped master for a one-pin serial bus that can run either the HDQ line protocol or the 1-Wire protocol. The pin is open drain: the block pulls the line low through `bus_drive_low` and reads the resolved level on `bus_in`. Software writes a byte to the transmit register. It then writes the control register with a start bit set, plus qualifiers that pick one of three operations: a line reset, a byte or bit write, or a byte or bit read. The block performs the operation. When it finishes, it clears the start bit, latches one of three completion flags and can raise a level interrupt.

Each waveform is measured in clock cycles and set by parameters. A line reset (in HDQ mode, a break) holds the line low and then releases it. In 1-Wire mode the line is sampled at a fixed cycle after the release to detect a slave's presence reply. A data slot starts with a low pulse. For a write, a short pulse means a one and a long pulse means a zero. For a read, a fixed short pulse is followed by one sample of the line. Bytes travel least significant bit first. In single-bit mode only bit 0 of a byte moves.

The bit engine `swire_phy` has six states. IDLE moves to RST_LOW on a reset start and to SLOT_LOW on a data start. RST_LOW moves to RST_REC when the low time ends. RST_REC moves to FINISH when the recovery time ends. SLOT_LOW moves to SLOT_REC when the pulse ends. SLOT_REC moves back to SLOT_LOW for the next bit, or to FINISH after the last bit. FINISH returns to IDLE and reports completion.

Top module: `swire_master`

## Requirements
- R1: After reset, all readable registers except the revision read 0, `irq` is 0 and the line is released.
- R2: The register byte offsets are: revision 0x00, transmit data 0x04, receive data 0x08, control 0x0C and completion status 0x10. The revision register reads {REV_MAJOR[3:0], REV_MINOR[3:0]} in bits 7:0. The control bits are: 7 single-bit, 6 interrupt enable, 5 engine enable, 4 start, 3 presence (read only), 2 reset request, 1 direction (1 = read) and 0 protocol (1 = 1-Wire, 0 = HDQ).
- R3: Each data slot lasts SLOT_LEN cycles. A written 1 pulls the line low for LOW_ONE cycles and a written 0 for LOW_ZERO cycles. Bits go least significant first, and the line is released outside the low pulses.
- R4: A start with direction 0 writes the transmit byte as eight slots. It then sets status bit 2 and clears the start bit.
- R5: A start with direction 1 runs eight read slots. Each slot pulls the line low for RD_LOW cycles and samples it RD_SAMPLE cycles after the slot begins. The bits are assembled least significant first into the receive register, status bit 1 is set and the start bit is cleared.
- R6: In 1-Wire mode, a start with the reset request holds the line low for RST_LOW cycles and then releases it for RST_REC cycles. The line is sampled PRES_AT cycles after the release, and the presence bit is set if the line is low then and cleared otherwise. Status bit 0 is set and both the start bit and the reset request bit are cleared.
- R7: In HDQ mode, a reset request holds the line low for BRK_LOW cycles and releases it for BRK_REC cycles. It sets status bit 0 and leaves the presence bit at 0 even if the line is pulled low.
- R8: With single-bit set, a transfer is one slot. A write sends transmit bit 0. A read writes the sampled bit to receive bit 0 and zero to bits 7:1.
- R9: Reading the status register returns the latched flags and clears them. `irq` is high exactly while a flag is latched and the interrupt enable is 1.
- R10: A start written with the engine enable at 0 is not taken: there are no pulses, the start bit reads 0 and no flag is latched.
- R11: While the start bit is 1, a control write changes only the interrupt enable. The operation in progress is not restarted or altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on the status offset) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data (bits 7:0 significant) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |
| bus_drive_low | output | 1 | 1 pulls the bus line low |
| bus_in | input | 1 | Sampled bus line level |

## Verification
The bench models a slave that decodes the pulse widths and answers read slots and resets by pulling the line low around the sample point. A bit order that is reversed, or a long/short pulse swap, shows up as a wrong decoded byte. A sample taken at the wrong cycle returns the wrong receive value or the wrong presence bit. An HDQ break that reports presence, or that uses the 1-Wire low time, shows up in the control readback and the measured width. A control write accepted during a running transfer adds pulses or latches a receive flag. A start accepted with the engine disabled produces pulses. A status read that does not clear, or an interrupt that ignores the enable, is caught on the second read and on `irq`.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RESET = 2'd2
    } swire_op_e;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_RST_LOW  = 3'd1,
        PS_RST_REC  = 3'd2,
        PS_SLOT_LOW = 3'd3,
        PS_SLOT_REC = 3'd4,
        PS_FINISH   = 3'd5
    } phy_state_e;

    // register byte offsets
    localparam int OFF_REV  = 'h00;
    localparam int OFF_TX   = 'h04;
    localparam int OFF_RX   = 'h08;
    localparam int OFF_CTRL = 'h0C;
    localparam int OFF_STAT = 'h10;

    // control bit positions
    localparam int CB_SINGLE = 7;
    localparam int CB_IE     = 6;
    localparam int CB_CLKEN  = 5;
    localparam int CB_GO     = 4;
    localparam int CB_PRES   = 3;
    localparam int CB_INIT   = 2;
    localparam int CB_DIR    = 1;
    localparam int CB_MODE   = 0;

    // status bit positions
    localparam int SB_TX  = 2;
    localparam int SB_RX  = 1;
    localparam int SB_RST = 0;

endpackage

// File: rtl/swire_phy.sv
module swire_phy
    import swire_pkg::*;
#(
    parameter int SLOT_LEN  = 40,
    parameter int LOW_ONE   = 4,
    parameter int LOW_ZERO  = 30,
    parameter int RD_LOW    = 3,
    parameter int RD_SAMPLE = 10,
    parameter int RST_LOW   = 80,
    parameter int RST_REC   = 80,
    parameter int PRES_AT   = 30,
    parameter int BRK_LOW   = 50,
    parameter int BRK_REC   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  swire_op_e  start_op,
    input  logic       start_mode_1w,
    input  logic       start_single,
    input  logic [7:0] start_tx,
    input  logic       bus_in,
    output logic       bus_drive_low,
    output logic       done,
    output swire_op_e  done_op,
    output logic [7:0] rx_byte,
    output logic       presence
);

    localparam int M1   = (RST_LOW > RST_REC) ? RST_LOW : RST_REC;
    localparam int M2   = (BRK_LOW > BRK_REC) ? BRK_LOW : BRK_REC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M3 > SLOT_LEN) ? M3 : SLOT_LEN;
    localparam int CW   = $clog2(MAXT + 1);

    phy_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    tx_q, sh_q;
    swire_op_e     op_q;
    logic          mode_q, single_q, pres_q;

    logic [CW-1:0] low_len, rst_low_len, rst_rec_len;
    logic          last_bit;

    always_comb begin
        if (op_q == OP_READ)   low_len = CW'(RD_LOW);
        else if (tx_q[bidx])   low_len = CW'(LOW_ONE);
        else                   low_len = CW'(LOW_ZERO);
        rst_low_len = mode_q ? CW'(RST_LOW) : CW'(BRK_LOW);
        rst_rec_len = mode_q ? CW'(RST_REC) : CW'(BRK_REC);
        last_bit    = single_q || (bidx == 3'd7);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE:     if (start) nxt = (start_op == OP_RESET) ? PS_RST_LOW : PS_SLOT_LOW;
            PS_RST_LOW:  if (cnt == rst_low_len - 1'b1) nxt = PS_RST_REC;
            PS_RST_REC:  if (cnt == rst_rec_len - 1'b1) nxt = PS_FINISH;
            PS_SLOT_LOW: if (cnt == low_len - 1'b1) nxt = PS_SLOT_REC;
            PS_SLOT_REC: if (cnt == CW'(SLOT_LEN - 1)) nxt = last_bit ? PS_FINISH : PS_SLOT_LOW;
            PS_FINISH:   nxt = PS_IDLE;
            default:     nxt = PS_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bidx     <= '0;
            tx_q     <= '0;
            sh_q     <= '0;
            op_q     <= OP_WRITE;
            mode_q   <= 1'b0;
            single_q <= 1'b0;
            pres_q   <= 1'b0;
        end else begin
            unique case (state)
                PS_IDLE: if (start) begin
                    cnt      <= '0;
                    bidx     <= '0;
                    sh_q     <= '0;
                    pres_q   <= 1'b0;
                    tx_q     <= start_tx;
                    op_q     <= start_op;
                    mode_q   <= start_mode_1w;
                    single_q <= start_single;
                end
                PS_RST_LOW: cnt <= (cnt == rst_low_len - 1'b1) ? '0 : cnt + 1'b1;
                PS_RST_REC: begin
                    cnt <= cnt + 1'b1;
                    if (mode_q && cnt == CW'(PRES_AT)) pres_q <= ~bus_in;
                end
                PS_SLOT_LOW: cnt <= cnt + 1'b1;
                PS_SLOT_REC: begin
                    if (op_q == OP_READ && cnt == CW'(RD_SAMPLE)) sh_q <= {bus_in, sh_q[7:1]};
                    if (cnt == CW'(SLOT_LEN - 1)) begin
                        cnt  <= '0;
                        bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PS_FINISH: cnt <= '0;
                default:   cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_drive_low = (state == PS_RST_LOW) || (state == PS_SLOT_LOW);
        done          = (state == PS_FINISH);
        done_op       = op_q;
        rx_byte       = single_q ? {7'b0, sh_q[7]} : sh_q;
        presence      = pres_q;
    end

    // R11: a start is only presented while the engine is idle
    a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == PS_IDLE);

    // R3: completion is reported for a single cycle
    a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/swire_regs.sv
module swire_regs
    import swire_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              start,
    output swire_op_e         start_op,
    output logic              start_mode_1w,
    output logic              start_single,
    output logic [7:0]        start_tx,
    input  logic              phy_done,
    input  swire_op_e         phy_done_op,
    input  logic [7:0]        phy_rx,
    input  logic              phy_presence
);

    localparam logic [7:0] REV_VAL = {4'(REV_MAJOR), 4'(REV_MINOR)};

    logic       single_q, ie_q, clken_q, go_q, pres_q, init_q, dir_q, mode_q;
    logic [7:0] tx_q, rx_q;
    logic [2:0] stat_q, stat_set;
    logic       ctrl_wr, tx_wr, stat_rd;
    logic       unused_bits;

    assign unused_bits = ^{reg_wdata[31:8], reg_wdata[CB_PRES]};

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign tx_wr   = reg_wr && (reg_addr == ADDR_W'(OFF_TX));
    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(OFF_STAT));

    always_comb begin
        start         = ctrl_wr && !go_q && reg_wdata[CB_GO] && reg_wdata[CB_CLKEN];
        start_op      = reg_wdata[CB_INIT] ? OP_RESET : (reg_wdata[CB_DIR] ? OP_READ : OP_WRITE);
        start_mode_1w = reg_wdata[CB_MODE];
        start_single  = reg_wdata[CB_SINGLE];
        start_tx      = tx_q;
        stat_set      = '0;
        if (phy_done) begin
            unique case (phy_done_op)
                OP_WRITE: stat_set[SB_TX]  = 1'b1;
                OP_READ:  stat_set[SB_RX]  = 1'b1;
                OP_RESET: stat_set[SB_RST] = 1'b1;
                default:  stat_set         = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {single_q, ie_q, clken_q, go_q, pres_q, init_q, dir_q, mode_q} <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            stat_q <= '0;
        end else begin
            if (tx_wr) tx_q <= reg_wdata[7:0];
            if (ctrl_wr) begin
                ie_q <= reg_wdata[CB_IE];
                if (!go_q) begin
                    single_q <= reg_wdata[CB_SINGLE];
                    clken_q  <= reg_wdata[CB_CLKEN];
                    init_q   <= reg_wdata[CB_INIT];
                    dir_q    <= reg_wdata[CB_DIR];
                    mode_q   <= reg_wdata[CB_MODE];
                    go_q     <= reg_wdata[CB_GO] && reg_wdata[CB_CLKEN];
                end
            end
            if (phy_done) begin
                go_q <= 1'b0;
                if (phy_done_op == OP_RESET) begin
                    init_q <= 1'b0;
                    pres_q <= phy_presence;
                end
                if (phy_done_op == OP_READ) rx_q <= phy_rx;
            end
            stat_q <= (stat_rd ? 3'b000 : stat_q) | stat_set;
        end
    end

    always_comb begin
        irq = ie_q && (stat_q != 3'b000);
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_REV))       reg_rdata[7:0] = REV_VAL;
        else if (reg_addr == ADDR_W'(OFF_TX))   reg_rdata[7:0] = tx_q;
        else if (reg_addr == ADDR_W'(OFF_RX))   reg_rdata[7:0] = rx_q;
        else if (reg_addr == ADDR_W'(OFF_CTRL))
            reg_rdata[7:0] = {single_q, ie_q, clken_q, go_q, pres_q, init_q, dir_q, mode_q};
        else if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata[2:0] = stat_q;
    end

    // R4: completion from the engine always drops the start bit
    a_r4_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        phy_done |=> !go_q);

    // R9: a status read with no new completion leaves nothing latched
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !phy_done) |=> (stat_q == 3'b000));

    // R6: presence only appears at the end of a line reset
    a_r6_presence_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pres_q) |-> $past(phy_done && phy_done_op == OP_RESET));

endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1,
    parameter int SLOT_LEN  = 40,
    parameter int LOW_ONE   = 4,
    parameter int LOW_ZERO  = 30,
    parameter int RD_LOW    = 3,
    parameter int RD_SAMPLE = 10,
    parameter int RST_LOW   = 80,
    parameter int RST_REC   = 80,
    parameter int PRES_AT   = 30,
    parameter int BRK_LOW   = 50,
    parameter int BRK_REC   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              bus_drive_low,
    input  logic              bus_in
);

    logic       start, start_mode_1w, start_single, phy_done, phy_presence;
    swire_op_e  start_op, phy_done_op;
    logic [7:0] start_tx, phy_rx;

    swire_regs #(
        .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .start(start), .start_op(start_op), .start_mode_1w(start_mode_1w),
        .start_single(start_single), .start_tx(start_tx),
        .phy_done(phy_done), .phy_done_op(phy_done_op),
        .phy_rx(phy_rx), .phy_presence(phy_presence)
    );

    swire_phy #(
        .SLOT_LEN(SLOT_LEN), .LOW_ONE(LOW_ONE), .LOW_ZERO(LOW_ZERO),
        .RD_LOW(RD_LOW), .RD_SAMPLE(RD_SAMPLE), .RST_LOW(RST_LOW),
        .RST_REC(RST_REC), .PRES_AT(PRES_AT), .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC)
    ) u_phy (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_op(start_op), .start_mode_1w(start_mode_1w),
        .start_single(start_single), .start_tx(start_tx),
        .bus_in(bus_in), .bus_drive_low(bus_drive_low),
        .done(phy_done), .done_op(phy_done_op),
        .rx_byte(phy_rx), .presence(phy_presence)
    );

endmodule

// File: tb/swire_master_tb.sv
module swire_master_tb;

    localparam int LOW_ONE = 4, LOW_ZERO = 30, RD_LOW = 3, RD_SAMPLE = 10;
    localparam int RST_LOW = 80, PRES_AT = 30, BRK_LOW = 50;
    localparam int A_REV = 'h00, A_TX = 'h04, A_RX = 'h08, A_CTRL = 'h0C, A_STAT = 'h10;
    localparam int C_SINGLE = 'h80, C_IE = 'h40, C_EN = 'h20, C_GO = 'h10;
    localparam int C_PRES = 'h08, C_INIT = 'h04, C_DIR = 'h02, C_1W = 'h01;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, bus_drive_low, bus_in, slave_pull;

    int checks = 0, fails = 0;

    // slave model state
    int widths [0:511];
    int nw = 0, low_run = 0, rel_cnt = 0, nrise = 0, rise_base = 0;
    logic prev_low = 0, resp_pres = 0, resp_read = 0;
    logic [7:0] slv_data = 0;

    always #5 clk = ~clk;

    swire_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bus_drive_low(bus_drive_low), .bus_in(bus_in)
    );

    assign bus_in = !(bus_drive_low || slave_pull);

    always_comb begin
        slave_pull = 1'b0;
        if (!bus_drive_low && resp_pres && rel_cnt >= 1 && rel_cnt <= PRES_AT + 2)
            slave_pull = 1'b1;
        if (!bus_drive_low && resp_read && rel_cnt >= 1 && rel_cnt <= RD_SAMPLE - RD_LOW + 2
            && nrise > rise_base && !slv_data[(nrise - rise_base - 1) & 7])
            slave_pull = 1'b1;
    end

    always @(negedge clk) begin
        if (bus_drive_low) begin
            low_run = low_run + 1;
            rel_cnt = 0;
            if (!prev_low) nrise = nrise + 1;
        end else begin
            if (low_run != 0) begin
                widths[nw & 511] = low_run;
                nw = nw + 1;
            end
            low_run = 0;
            rel_cnt = rel_cnt + 1;
        end
        prev_low = bus_drive_low;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 5'(a); reg_wdata = 32'(d); reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 5'(a); reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(A_CTRL, v);
            if (!v[4]) return;
        end
        check(req, 32'hDEAD, 32'h0);
    endtask

    function automatic logic [7:0] decode(input int base, input int n);
        logic [7:0] b = 0;
        for (int i = 0; i < n && i < 8; i++) b[i] = (widths[(base + i) & 511] == LOW_ONE);
        return b;
    endfunction

    task automatic t_reset_state();
        logic [31:0] v;
        check("R1 line released", 32'(bus_drive_low), 0);
        check("R1 irq low", 32'(irq), 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_RX, v);   check("R1 rx", v, 0);
        rd(A_TX, v);   check("R1 tx", v, 0);
    endtask

    task automatic t_revision();
        logic [31:0] v;
        rd(A_REV, v); check("R2 revision", v, 32'h21);
    endtask

    task automatic t_write_byte(input logic [7:0] b);
        logic [31:0] v;
        int base = nw;
        wr(A_TX, b);
        wr(A_CTRL, C_IE | C_EN | C_GO | C_1W);
        wait_idle("R4 write completes");
        check("R3 write pulse count", 32'(nw - base), 8);
        check("R3 R4 written byte lsb first", 32'(decode(base, nw - base)), 32'(b));
        check("R9 irq raised with enable", 32'(irq), 1);
        rd(A_STAT, v); check("R4 tx complete flag", v, 4);
        rd(A_CTRL, v); check("R4 go cleared", v, C_IE | C_EN | C_1W);
    endtask

    task automatic t_read_byte(input logic [7:0] b);
        logic [31:0] v;
        slv_data = b; rise_base = nrise; resp_read = 1;
        wr(A_CTRL, C_IE | C_EN | C_GO | C_DIR | C_1W);
        wait_idle("R5 read completes");
        resp_read = 0;
        rd(A_RX, v);   check("R5 received byte", v, 32'(b));
        rd(A_STAT, v); check("R5 rx complete flag", v, 2);
    endtask

    task automatic t_reset_1w(input logic answer);
        logic [31:0] v;
        int base = nw;
        resp_pres = answer;
        wr(A_CTRL, C_IE | C_EN | C_GO | C_INIT | C_1W);
        wait_idle("R6 reset completes");
        resp_pres = 0;
        check("R6 reset low width", 32'(widths[base & 511]), RST_LOW);
        rd(A_CTRL, v);
        check("R6 presence and cleared init/go", v, C_IE | C_EN | C_1W | (answer ? C_PRES : 0));
        rd(A_STAT, v); check("R6 reset flag", v, 1);
    endtask

    task automatic t_break_hdq();
        logic [31:0] v;
        int base = nw;
        resp_pres = 1;
        wr(A_CTRL, C_IE | C_EN | C_GO | C_INIT);
        wait_idle("R7 break completes");
        resp_pres = 0;
        check("R7 break low width", 32'(widths[base & 511]), BRK_LOW);
        rd(A_CTRL, v); check("R7 no presence in HDQ", v, C_IE | C_EN);
        rd(A_STAT, v); check("R7 reset flag", v, 1);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int base = nw;
        wr(A_TX, 8'h02);
        wr(A_CTRL, C_IE | C_EN | C_GO | C_SINGLE | C_1W);
        wait_idle("R8 single write completes");
        check("R8 single write one slot", 32'(nw - base), 1);
        check("R8 single write uses bit0", 32'(widths[base & 511]), LOW_ZERO);
        rd(A_STAT, v); check("R8 single write flag", v, 4);
        slv_data = 8'h01; rise_base = nrise; resp_read = 1;
        wr(A_CTRL, C_IE | C_EN | C_GO | C_SINGLE | C_DIR | C_1W);
        wait_idle("R8 single read completes");
        resp_read = 0;
        rd(A_RX, v); check("R8 single read into bit0", v, 1);
        rd(A_STAT, v); check("R8 single read flag", v, 2);
    endtask

    task automatic t_irq_enable();
        logic [31:0] v;
        wr(A_TX, 8'h81);
        wr(A_CTRL, C_EN | C_GO | C_1W);
        wait_idle("R9 write completes");
        check("R9 irq masked when disabled", 32'(irq), 0);
        wr(A_CTRL, C_IE | C_EN | C_1W);
        check("R9 irq follows enable", 32'(irq), 1);
        rd(A_STAT, v); check("R9 first read returns flag", v, 4);
        check("R9 irq drops after clear", 32'(irq), 0);
        rd(A_STAT, v); check("R9 second read empty", v, 0);
    endtask

    task automatic t_engine_off();
        logic [31:0] v;
        int base = nw;
        wr(A_CTRL, C_IE | C_GO | C_1W);
        repeat (200) @(negedge clk);
        check("R10 no pulses when disabled", 32'(nw - base), 0);
        rd(A_CTRL, v); check("R10 start not taken", v & C_GO, 0);
        rd(A_STAT, v); check("R10 no flag", v, 0);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        int base = nw;
        wr(A_TX, 8'hFF);
        wr(A_CTRL, C_IE | C_EN | C_GO | C_1W);
        repeat (20) @(negedge clk);
        wr(A_CTRL, C_IE | C_EN | C_GO | C_DIR | C_SINGLE | C_INIT | C_1W);
        wait_idle("R11 write completes");
        check("R11 pulses unchanged", 32'(nw - base), 8);
        check("R11 byte unchanged", 32'(decode(base, nw - base)), 32'hFF);
        rd(A_STAT, v); check("R11 only tx flag", v, 4);
        rd(A_CTRL, v); check("R11 qualifiers not written", v, C_IE | C_EN | C_1W);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_revision();
        t_write_byte(8'hA5);
        t_write_byte(8'h3C);
        t_read_byte(8'h3C);
        t_read_byte(8'hC1);
        t_reset_1w(1'b1);
        t_reset_1w(1'b0);
        t_break_hdq();
        t_single();
        t_irq_enable();
        t_engine_off();
        t_busy_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule